// File: doc/BRIEF.md
# Self-Timed Byte-Writable Nonvolatile Memory Core

This block is a clocked behavioural model of a 2K x 8 byte-writable nonvolatile memory that is accessed like a static RAM. A system clock samples three active-low strobes (chip select, output enable, write strobe), an 11-bit address and an 8-bit data input. When the chip-select and write strobes overlap, the block captures an address and a data byte. Once the overlap ends it programs that byte on its own, using an internal cycle counter.

While programming runs, an open-drain busy enable is asserted. Any read returns the complement of bit 7 of the byte being written, so software can poll for completion. Writes are gated by a supply-good input with a power-up hold-off, and by the output-enable strobe. Two flag inputs stand in for high-voltage pins. The first maps the top 32 addresses onto a separate identification array. The second enables a chip clear that sets the whole main array to 0xFF.

Top module: `eep_core`

## Requirements
- R1: A read is in effect in any sample where cs_n=0, oe_n=0 and wr_n=1. In that case rd_valid=1 in the same cycle and rd_data holds the addressed byte. Whenever cs_n or oe_n is 1, rd_valid=0 and rd_data=0.
- R2: A write is armed in the first sample where cs_n and wr_n are both 0, provided oe_n=1. The address of that sample is captured. The data byte is taken from the last sample in which both strobes are still 0.
- R3: The sample where either strobe is seen high ends the arming. busy_od=1 then holds for exactly WR_CYCLES cycles starting at the next cycle. The new byte is readable in the first cycle after busy_od falls.
- R4: While busy_od=1, a read returns bit 7 inverted and bits 6:0 unchanged from the captured data byte, whatever the address.
- R5: Strobe activity while busy_od=1 is ignored, and the captured address and data stay fixed. An overlap that is still held when busy ends starts no write.
- R6: A write can be armed or completed only when supply_ok=1 now and supply_ok was also 1 on at least POR_CYCLES preceding clock edges. Outside that window no byte changes.
- R7: oe_n=0 during the strobe overlap prevents or aborts the write.
- R8: With hv_a9=1, addresses 0x7E0 to 0x7FF read and write a separate 32-byte identification array indexed by addr[4:0]. The main array bytes at those addresses are untouched.
- R9: Chip clear follows cs_n=0, hv_oe=1 and wr_n=0 held for at least CLR_CYCLES samples, then wr_n seen high. It sets every main byte to 0xFF and leaves the identification array alone. A shorter pulse does nothing. Strobe overlaps with hv_oe=1 arm no byte write.
- R10: After reset every byte of both arrays reads 0xFF, busy_od=0, and the power-up hold-off restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 11 | Byte address |
| wdata | input | 8 | Write data |
| supply_ok | input | 1 | Supply-good flag |
| hv_a9 | input | 1 | Identification-row select flag |
| hv_oe | input | 1 | Chip-clear enable flag |
| rd_data | output | 8 | Read data, zero when not reading |
| rd_valid | output | 1 | Read data drive enable |
| busy_od | output | 1 | Open-drain pull-down enable, 1 while programming |

## Verification
Byte writes are applied in several ways. Some strobes have the address moved after the first overlap sample and the data changed only in the last one, which separates the capture points for address and data. Polling reads during programming, at the written address and at other addresses, show whether bit 7 is inverted from the captured byte rather than read from the array. A second write launched during busy and an overlap held across busy end test that the latches stay frozen and that nothing starts on a stale overlap. Lockout windows, an output-enable-low strobe, identification-row accesses and both short and long clear pulses each run against a behavioural reference that is compared every cycle.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2
    } wr_state_e;
endpackage

// File: rtl/eep_lockout.sv
module eep_lockout #(
    parameter int POR_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic unlocked
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] CMAX = CW'(POR_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!supply_ok)        cnt_d = '0;
        else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign unlocked = supply_ok && (cnt_q == CMAX);
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int ID_DEPTH   = 32,
    parameter int WR_CYCLES  = 40,
    parameter int CLR_CYCLES = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              hv_a9,
    input  logic              hv_oe,
    input  logic              unlocked,
    output logic              busy,
    output logic              commit,
    output logic              lat_id,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_data,
    output logic              clear
);
    localparam int ID_AW = $clog2(ID_DEPTH);
    localparam int WCW   = $clog2(WR_CYCLES + 1);
    localparam int CCW   = $clog2(CLR_CYCLES + 1);
    localparam logic [CCW-1:0] CLR_MAX = CCW'(CLR_CYCLES);

    typedef struct packed {
        wr_state_e         state;
        logic              id;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [WCW-1:0]    wcnt;
        logic [CCW-1:0]    ccnt;
        logic              stb;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  stb, id_hit, clr_hold;

    assign stb      = !cs_n && !wr_n;
    assign id_hit   = hv_a9 && (&addr[ADDR_W-1:ID_AW]);
    assign clr_hold = !cs_n && hv_oe && !wr_n && unlocked;

    always_comb begin
        r_d     = r_q;
        r_d.stb = stb;
        commit  = 1'b0;
        clear   = 1'b0;
        r_d.ccnt = clr_hold ? ((r_q.ccnt == CLR_MAX) ? r_q.ccnt : r_q.ccnt + 1'b1) : '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (stb && !r_q.stb && oe_n && !hv_oe && unlocked) begin
                    r_d.state = ST_ARMED;
                    r_d.addr  = addr;
                    r_d.id    = id_hit;
                    r_d.data  = wdata;
                end
                if (r_q.ccnt == CLR_MAX && !cs_n && hv_oe && wr_n && unlocked)
                    clear = 1'b1;
            end
            ST_ARMED: begin
                if (!unlocked || !oe_n) begin
                    r_d.state = ST_IDLE;
                end else if (stb) begin
                    r_d.data = wdata;
                end else begin
                    r_d.state = ST_BUSY;
                    r_d.wcnt  = WCW'(WR_CYCLES - 1);
                end
            end
            ST_BUSY: begin
                if (r_q.wcnt == '0) begin
                    commit    = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.wcnt = r_q.wcnt - 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state == ST_BUSY);
    assign lat_id   = r_q.id;
    assign lat_addr = r_q.addr;
    assign lat_data = r_q.data;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int ID_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_id,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic              rd_id,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int ID_AW = $clog2(ID_DEPTH);

    logic [DATA_W-1:0] main_q [DEPTH];
    logic [DATA_W-1:0] id_q   [ID_DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
        end else if (clr) begin
            for (int i = 0; i < DEPTH; i++) main_q[i] <= '1;
        end else if (wr_en && !wr_id) begin
            main_q[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ID_DEPTH; i++) id_q[i] <= '1;
        end else if (wr_en && wr_id) begin
            id_q[wr_addr[ID_AW-1:0]] <= wr_data;
        end
    end

    assign rd_data = rd_id ? id_q[rd_addr[ID_AW-1:0]] : main_q[rd_addr];
endmodule

// File: rtl/eep_core.sv
module eep_core #(
    parameter int ADDR_W     = 11,
    parameter int DATA_W     = 8,
    parameter int ID_DEPTH   = 32,
    parameter int WR_CYCLES  = 40,
    parameter int POR_CYCLES = 25,
    parameter int CLR_CYCLES = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              supply_ok,
    input  logic              hv_a9,
    input  logic              hv_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy_od
);
    localparam int ID_AW = $clog2(ID_DEPTH);

    logic              unlocked, busy, commit, clear, lat_id, rd_id, reading;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data, arr_data;

    eep_lockout #(.POR_CYCLES(POR_CYCLES)) u_lock (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .unlocked(unlocked)
    );

    eep_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_DEPTH(ID_DEPTH),
        .WR_CYCLES(WR_CYCLES), .CLR_CYCLES(CLR_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .hv_a9(hv_a9), .hv_oe(hv_oe),
        .unlocked(unlocked), .busy(busy), .commit(commit), .lat_id(lat_id),
        .lat_addr(lat_addr), .lat_data(lat_data), .clear(clear)
    );

    assign rd_id = hv_a9 && (&addr[ADDR_W-1:ID_AW]);

    eep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_DEPTH(ID_DEPTH)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_id(lat_id),
        .wr_addr(lat_addr), .wr_data(lat_data), .clr(clear),
        .rd_id(rd_id), .rd_addr(addr), .rd_data(arr_data)
    );

    assign reading  = !cs_n && !oe_n && wr_n;
    assign rd_valid = reading;
    assign busy_od  = busy;

    always_comb begin
        if (!reading)  rd_data = '0;
        else if (busy) rd_data = {~lat_data[DATA_W-1], lat_data[DATA_W-2:0]};
        else           rd_data = arr_data;
    end
endmodule

// File: rtl/eep_core_chk.sv
module eep_core_chk #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              supply_ok,
    input logic              busy_od,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] lat_addr,
    input logic [DATA_W-1:0] lat_data
);
    localparam int RW = $clog2(WR_CYCLES + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (busy_od) run_q <= (run_q == RW'(WR_CYCLES + 1)) ? run_q : run_q + 1'b1;
        else              run_q <= '0;
    end

    p_read_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n) |-> (!rd_valid && rd_data == '0));

    p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_od |-> (run_q < RW'(WR_CYCLES)));

    p_poll_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_od && rd_valid) |-> (rd_data[DATA_W-1] == ~lat_data[DATA_W-1]));

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_od && $past(busy_od)) |-> ($stable(lat_addr) && $stable(lat_data)));

    p_supply_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!supply_ok && !busy_od) |=> !busy_od);

    p_oe_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !busy_od) |=> !busy_od);
endmodule

bind eep_core eep_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .supply_ok(supply_ok),
    .busy_od(busy_od), .rd_valid(rd_valid), .rd_data(rd_data),
    .lat_addr(lat_addr), .lat_data(lat_data)
);

// File: tb/tb_eep_core.sv
module tb_eep_core;
    localparam int CLK_P = 10;
    localparam int WR    = 40;
    localparam int POR   = 25;
    localparam int CLR   = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, oe_n = 1'b1, wr_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic supply_ok = 1'b1, hv_a9 = 1'b0, hv_oe = 1'b0;
    logic [7:0] rd_data;
    logic rd_valid, busy_od;

    eep_core #(.WR_CYCLES(WR), .POR_CYCLES(POR), .CLR_CYCLES(CLR)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .supply_ok(supply_ok), .hv_a9(hv_a9),
        .hv_oe(hv_oe), .rd_data(rd_data), .rd_valid(rd_valid), .busy_od(busy_od)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference
    logic [7:0] m_main [2048];
    logic [7:0] m_id   [32];
    int  m_phase, m_left, m_por, m_clr;
    bit  m_prev, m_wid;
    logic [10:0] m_addr;
    logic [7:0]  m_data;

    int vectors = 0, errs = 0, cycles = 0;
    bit cmp_on = 1'b0, done = 1'b0;
    string cur_req = "R10";

    function automatic bit id_sel(input logic [10:0] a, input logic f);
        return f && (a >= 11'h7E0);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_main[i]) m_main[i] = 8'hFF;
            foreach (m_id[i])   m_id[i]   = 8'hFF;
            m_phase = 0; m_left = 0; m_por = 0; m_clr = 0; m_prev = 0;
            m_wid = 0; m_addr = '0; m_data = '0;
        end else begin
            bit s, ok;
            int por_next, clr_next;
            s  = !cs_n && !wr_n;
            ok = supply_ok && (m_por >= POR);
            por_next = supply_ok ? ((m_por < POR) ? m_por + 1 : POR) : 0;
            clr_next = (!cs_n && hv_oe && !wr_n && ok) ? ((m_clr < CLR) ? m_clr + 1 : CLR) : 0;
            if (m_phase == 0) begin
                if (m_clr >= CLR && !cs_n && hv_oe && wr_n && ok)
                    foreach (m_main[i]) m_main[i] = 8'hFF;
                if (s && !m_prev && oe_n && !hv_oe && ok) begin
                    m_phase = 1; m_addr = addr; m_data = wdata; m_wid = id_sel(addr, hv_a9);
                end
            end else if (m_phase == 1) begin
                if (!ok || !oe_n) m_phase = 0;
                else if (s) m_data = wdata;
                else begin m_phase = 2; m_left = WR; end
            end else begin
                m_left--;
                if (m_left == 0) begin
                    if (m_wid) m_id[m_addr[4:0]] = m_data;
                    else       m_main[m_addr]    = m_data;
                    m_phase = 0;
                end
            end
            m_prev = s; m_por = por_next; m_clr = clr_next;
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    endtask

    // compare every cycle, a quarter period after the driving edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (cmp_on) begin
            logic [7:0] e_d;
            bit e_v, e_b;
            e_b = rst_n && (m_phase == 2);
            e_v = !cs_n && !oe_n && wr_n;
            if (!e_v)     e_d = 8'h00;
            else if (e_b) e_d = {~m_data[7], m_data[6:0]};
            else          e_d = id_sel(addr, hv_a9) ? m_id[addr[4:0]] : m_main[addr];
            vectors++;
            if (rd_valid !== e_v || rd_data !== e_d || busy_od !== e_b) begin
                errs++;
                $display("FAIL %s t=%0t: got valid=%b data=%h busy=%b exp valid=%b data=%h busy=%b",
                         cur_req, $time, rd_valid, rd_data, busy_od, e_v, e_d, e_b);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errs++;
            $display("FAIL watchdog expired exp finish got hang");
            summary();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs_n = 1; oe_n = 1; wr_n = 1; hv_oe = 0;
        end
    endtask

    task automatic rd(input logic [10:0] a);
        @(negedge clk);
        cs_n = 0; oe_n = 0; wr_n = 1; addr = a;
    endtask

    // address moves after first overlap sample; data valid only in last
    task automatic wr(input logic [10:0] a, input logic [7:0] d, input int hold);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            cs_n = 0; wr_n = 0; oe_n = 1;
            addr  = (i == 0) ? a : ~a;
            wdata = (i == hold - 1) ? d : ~d;
        end
        @(negedge clk);
        cs_n = 1; wr_n = 1; addr = ~a;
    endtask

    initial begin
        @(posedge clk); cmp_on = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R10"; rd(11'h000); rd(11'h7FF); rd(11'h3A5); idle(1);
        cur_req = "R6"; wr(11'h055, 8'h12, 2); rd(11'h055); idle(POR);

        cur_req = "R2"; wr(11'h123, 8'h5A, 3);
        cur_req = "R4"; rd(11'h123); rd(11'h000); rd(11'h7FF); idle(2); rd(11'h123);
        cur_req = "R3"; idle(WR); rd(11'h123); rd(11'h124);
        cur_req = "R1"; @(negedge clk); cs_n = 1; oe_n = 0; addr = 11'h123;
        @(negedge clk); cs_n = 0; oe_n = 1; idle(1);

        cur_req = "R5"; wr(11'h010, 8'hC3, 2); idle(3); wr(11'h011, 8'h99, 2);
        @(negedge clk); cs_n = 0; wr_n = 0; oe_n = 1; addr = 11'h012; wdata = 8'h77;
        repeat (WR) @(negedge clk);
        idle(2); rd(11'h010); rd(11'h011); rd(11'h012);

        cur_req = "R7"; @(negedge clk); cs_n = 0; wr_n = 0; oe_n = 0; addr = 11'h030; wdata = 8'h01;
        @(negedge clk); idle(3); rd(11'h030);
        @(negedge clk); cs_n = 0; wr_n = 0; oe_n = 1; addr = 11'h031; wdata = 8'h02;
        @(negedge clk); oe_n = 0; @(negedge clk); idle(3); rd(11'h031);

        cur_req = "R6"; @(negedge clk); supply_ok = 0; wr(11'h020, 8'h11, 2); idle(2); rd(11'h020);
        @(negedge clk); supply_ok = 1; idle(10); wr(11'h020, 8'h22, 2); idle(2); rd(11'h020);
        idle(POR); wr(11'h020, 8'h33, 2); @(negedge clk); supply_ok = 0; idle(WR + 2); rd(11'h020);
        @(negedge clk); supply_ok = 1; idle(POR + 2);

        cur_req = "R8"; @(negedge clk); hv_a9 = 1; wr(11'h7E3, 8'h42, 2); idle(WR + 2);
        rd(11'h7E3); @(negedge clk); hv_a9 = 0; rd(11'h7E3);
        wr(11'h7E4, 8'h24, 2); idle(WR + 2); @(negedge clk); hv_a9 = 1; rd(11'h7E4);
        @(negedge clk); hv_a9 = 0; rd(11'h7E4); idle(1);

        cur_req = "R9"; @(negedge clk); hv_oe = 1; cs_n = 0; wr_n = 0; oe_n = 1; addr = 11'h100;
        repeat (10) @(negedge clk); wr_n = 1; @(negedge clk); idle(1); rd(11'h123);
        @(negedge clk); hv_oe = 1; cs_n = 0; wr_n = 0; oe_n = 1;
        repeat (CLR + 4) @(negedge clk); wr_n = 1; @(negedge clk); idle(2);
        rd(11'h123); rd(11'h010); rd(11'h7E4);
        @(negedge clk); hv_a9 = 1; rd(11'h7E3); @(negedge clk); hv_a9 = 0; idle(2);

        cur_req = "R10"; @(negedge clk); rst_n = 0; idle(2); @(negedge clk); rst_n = 1;
        rd(11'h7E3); wr(11'h040, 8'h44, 2); idle(2); rd(11'h040); idle(4);
        summary();
    end
endmodule